// File: doc/BRIEF.md
# Step/Direction Microstep Indexer with Per-Bridge Decay Choice

This block turns a step/direction command stream into current setpoints for the two windings of a bipolar stepper motor. A 6-bit electrical position walks a 64-slot cycle of 5.625-degree slots. Each rising edge of the step input moves it by an amount that a three-bit resolution select sets. The direction input sets the sign of the move. For each winding the block gives a 7-bit magnitude code and a polarity bit. For each bridge it gives a decay flag that a current chopper downstream uses to pick slow or mixed decay.

The step, direction, resolution and force-mixed inputs are asynchronous to the block clock. Each passes through two flip-flops before use. Direction, resolution and force-mixed take effect only at the synchronised rising edge of the step input. The active-low home input holds the position at the 45-degree slot. That slot lies on the grid of every resolution. The synchronous active-high `rst` does the same at power-up.

Top module: `step_indexer`

## Requirements
- R1: Resolution select bits {res_sel[2], res_sel[1], res_sel[0]} move the position per step by: 000 sixteen slots (full), 001 eight (half), 010 four (quarter), 011 two (eighth), 111 one (sixteenth). The unlisted codes 100, 101 and 110 also move one slot.
- R2: With dir_in high each step raises the position; with dir_in low it lowers it. The position wraps modulo 64 both ways. An off-grid position receives the increment unchanged.
- R3: Direction, resolution and force-mixed are sampled only at a synchronised step rising edge. Without such an edge, position, magnitudes and decay flags hold.
- R4: At position k, winding 1 carries cos(k*5.625 deg) and winding 2 carries sin(k*5.625 deg). Each magnitude code is round(127*|value|). A polarity bit is 1 only when its value is negative, so a zero magnitude is never negative.
- R5: After `rst` the position is slot 8, so both magnitudes read 90 with polarity 0, and both decay flags read mixed (1).
- R6: While home_n is low the position holds at slot 8 and step edges are lost. Outputs read the home magnitudes and both flags read mixed one clock after home_n is sampled low.
- R7: On a step, a bridge whose new magnitude is below its previous magnitude gets mixed decay (flag 1). A bridge whose new magnitude is equal or higher gets slow decay (flag 0).
- R8: A step taken at resolution code 000 sets both flags to slow, unless force-mixed was sampled high.
- R9: A step taken with force_mixed sampled high sets both flags to mixed in every resolution.
- R10: A rising step_in first sampled at clock edge n shows on the magnitude, polarity and decay outputs after edge n+3, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| home_n | input | 1 | Active-low hold-at-home |
| step_in | input | 1 | Step command; rising edge advances |
| dir_in | input | 1 | Direction, 1 raises the angle |
| res_sel | input | 3 | Resolution select, encoded as in R1 |
| force_mixed | input | 1 | Use mixed decay on every step |
| ph1_mag | output | 7 | Winding 1 (cosine) magnitude code |
| ph1_neg | output | 1 | Winding 1 current negative |
| ph2_mag | output | 7 | Winding 2 (sine) magnitude code |
| ph2_neg | output | 1 | Winding 2 current negative |
| ph1_mixed | output | 1 | Bridge 1 decay: 1 mixed, 0 slow |
| ph2_mixed | output | 1 | Bridge 2 decay: 1 mixed, 0 slow |

## Verification
The assertions watch several rules on every cycle. Each step moves the position by a power of two either way. The position holds between steps. A zero magnitude never carries a negative sign. At least one winding always sits at or above the 45-degree level. Force-mixed and full-step steps set the flags they must set, and holding home yields the home outputs. Only the bench's scenarios can show the exact trigonometric magnitudes at each slot, the wrap below slot 0, the three-edge latency, and the per-bridge rising-versus-falling decay choice. The bench shows these by comparing against a behavioural model on every clock.

// File: rtl/stx_pkg.sv
package stx_pkg;
  localparam int IDX_W    = 6;
  localparam int MAG_W    = 7;
  localparam int RES_W    = 3;
  localparam int HOME_IDX = 8;

  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [MAG_W-1:0] mag_t;

  typedef struct packed {
    mag_t mag;
    logic neg;
  } setpt_t;

  // quarter-wave sine, 127 = full scale, a = 0..16
  function automatic mag_t quarter_mag(input logic [4:0] a);
    case (a)
      5'd0:  quarter_mag = 7'd0;
      5'd1:  quarter_mag = 7'd12;
      5'd2:  quarter_mag = 7'd25;
      5'd3:  quarter_mag = 7'd37;
      5'd4:  quarter_mag = 7'd49;
      5'd5:  quarter_mag = 7'd60;
      5'd6:  quarter_mag = 7'd71;
      5'd7:  quarter_mag = 7'd81;
      5'd8:  quarter_mag = 7'd90;
      5'd9:  quarter_mag = 7'd98;
      5'd10: quarter_mag = 7'd106;
      5'd11: quarter_mag = 7'd112;
      5'd12: quarter_mag = 7'd117;
      5'd13: quarter_mag = 7'd122;
      5'd14: quarter_mag = 7'd125;
      5'd15: quarter_mag = 7'd126;
      default: quarter_mag = 7'd127;
    endcase
  endfunction

  // signed sine setpoint at slot k
  function automatic setpt_t sine_at(input idx_t k);
    logic [4:0] q;
    logic [4:0] a;
    setpt_t r;
    q = k[4:0];
    a = (q <= 5'd16) ? q : 5'(6'd32 - {1'b0, q});
    r.mag = quarter_mag(a);
    r.neg = k[5] && (q != 5'd0);
    return r;
  endfunction

  function automatic idx_t step_size(input logic [RES_W-1:0] res);
    case (res)
      3'b000:  step_size = idx_t'(16);
      3'b001:  step_size = idx_t'(8);
      3'b010:  step_size = idx_t'(4);
      3'b011:  step_size = idx_t'(2);
      default: step_size = idx_t'(1);
    endcase
  endfunction
endpackage

// File: rtl/stx_sync.sv
module stx_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else if (i == 0) stg[i] <= d;
        else stg[i] <= stg[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/stx_index.sv
module stx_index
  import stx_pkg::*;
(
  input  logic             clk,
  input  logic             clr,
  input  logic             rise,
  input  logic             dir,
  input  logic [RES_W-1:0] res,
  input  logic             force_in,
  output idx_t             idx,
  output logic             pulse,
  output logic             full_cap,
  output logic             force_cap
);
  idx_t inc;
  assign inc = step_size(res);

  always_ff @(posedge clk) begin
    if (clr) begin
      idx       <= idx_t'(HOME_IDX);
      pulse     <= 1'b0;
      full_cap  <= 1'b0;
      force_cap <= 1'b0;
    end else begin
      pulse <= rise;
      if (rise) begin
        idx       <= dir ? idx + inc : idx - inc;
        full_cap  <= (res == 3'b000);
        force_cap <= force_in;
      end
    end
  end

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (clr)
    !rise |=> $stable(idx)) else $error("idx moved without step"); // R3

  AST_IDX_POW2: assert property (@(posedge clk) disable iff (clr)
    rise |=> ($onehot(6'(idx - $past(idx))) || $onehot(6'($past(idx) - idx))))
    else $error("step not a power of two"); // R1
endmodule

// File: rtl/stx_wave.sv
module stx_wave
  import stx_pkg::*;
(
  input  logic       clk,
  input  logic       clr,
  input  idx_t       idx,
  output mag_t [1:0] mag_new,
  output mag_t [1:0] mag_q,
  output logic [1:0] neg_q
);
  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_ph
      // winding 0 leads by a quarter cycle (cosine)
      localparam int OFS = (g == 0) ? 16 : 0;
      setpt_t nxt;
      setpt_t home;
      assign nxt     = sine_at(idx + idx_t'(OFS));
      assign home    = sine_at(idx_t'(HOME_IDX + OFS));
      assign mag_new[g] = nxt.mag;

      always_ff @(posedge clk) begin
        if (clr) begin
          mag_q[g] <= home.mag;
          neg_q[g] <= home.neg;
        end else begin
          mag_q[g] <= nxt.mag;
          neg_q[g] <= nxt.neg;
        end
      end

      AST_ZERO_POSITIVE: assert property (@(posedge clk) disable iff (clr)
        neg_q[g] |-> (mag_q[g] != '0)) else $error("negative zero"); // R4
    end
  endgenerate

  AST_ONE_STRONG: assert property (@(posedge clk) disable iff (clr)
    (mag_q[0] >= 7'd90) || (mag_q[1] >= 7'd90)) else $error("both weak"); // R4
endmodule

// File: rtl/stx_decay.sv
module stx_decay
  import stx_pkg::*;
(
  input  logic       clk,
  input  logic       clr,
  input  logic       pulse,
  input  logic       full,
  input  logic       force_mix,
  input  mag_t [1:0] mag_new,
  input  mag_t [1:0] mag_old,
  output logic [1:0] mixed
);
  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_br
      always_ff @(posedge clk) begin
        if (clr) mixed[g] <= 1'b1;
        else if (pulse) begin
          if (force_mix) mixed[g] <= 1'b1;
          else if (full) mixed[g] <= 1'b0;
          else mixed[g] <= (mag_new[g] < mag_old[g]);
        end
      end
    end
  endgenerate

  AST_FORCE_MIX: assert property (@(posedge clk) disable iff (clr)
    (pulse && force_mix) |=> (mixed == 2'b11)) else $error("force ignored"); // R9

  AST_FULL_SLOW: assert property (@(posedge clk) disable iff (clr)
    (pulse && full && !force_mix) |=> (mixed == 2'b00)) else $error("full not slow"); // R8

  AST_DECAY_HOLD: assert property (@(posedge clk) disable iff (clr)
    !pulse |=> $stable(mixed)) else $error("decay moved"); // R3
endmodule

// File: rtl/step_indexer.sv
module step_indexer
  import stx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             home_n,
  input  logic             step_in,
  input  logic             dir_in,
  input  logic [RES_W-1:0] res_sel,
  input  logic             force_mixed,
  output logic [MAG_W-1:0] ph1_mag,
  output logic             ph1_neg,
  output logic [MAG_W-1:0] ph2_mag,
  output logic             ph2_neg,
  output logic             ph1_mixed,
  output logic             ph2_mixed
);
  localparam int BW = RES_W + 3;

  logic [BW-1:0]    raw, syn;
  logic             s_step, s_dir, s_force, step_d, rise, clr;
  logic [RES_W-1:0] s_res;
  idx_t             idx;
  logic             pulse, full_cap, force_cap;
  mag_t [1:0]       mag_new, mag_q;
  logic [1:0]       neg_q, mixed;

  assign raw = {force_mixed, res_sel, dir_in, step_in};

  stx_sync #(.W(BW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(syn)
  );

  assign {s_force, s_res, s_dir, s_step} = syn;

  always_ff @(posedge clk) begin
    if (rst) step_d <= 1'b0;
    else     step_d <= s_step;
  end

  assign rise = s_step & ~step_d;
  assign clr  = rst | ~home_n;

  stx_index u_index (
    .clk(clk), .clr(clr), .rise(rise), .dir(s_dir), .res(s_res),
    .force_in(s_force), .idx(idx), .pulse(pulse),
    .full_cap(full_cap), .force_cap(force_cap)
  );

  stx_wave u_wave (
    .clk(clk), .clr(clr), .idx(idx),
    .mag_new(mag_new), .mag_q(mag_q), .neg_q(neg_q)
  );

  stx_decay u_decay (
    .clk(clk), .clr(clr), .pulse(pulse), .full(full_cap),
    .force_mix(force_cap), .mag_new(mag_new), .mag_old(mag_q),
    .mixed(mixed)
  );

  assign ph1_mag   = mag_q[0];
  assign ph1_neg   = neg_q[0];
  assign ph2_mag   = mag_q[1];
  assign ph2_neg   = neg_q[1];
  assign ph1_mixed = mixed[0];
  assign ph2_mixed = mixed[1];

  AST_HOME_HOLD: assert property (@(posedge clk) disable iff (rst)
    !home_n |=> (ph1_mag == 7'd90 && ph2_mag == 7'd90 && !ph1_neg && !ph2_neg
                 && ph1_mixed && ph2_mixed)) else $error("home not held"); // R6
endmodule

// File: tb/tb_step_indexer.sv
module tb_step_indexer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       home_n = 1'b1;
  logic       step_in = 1'b0;
  logic       dir_in = 1'b1;
  logic [2:0] res_sel = 3'b000;
  logic       force_mixed = 1'b0;
  logic [6:0] ph1_mag, ph2_mag;
  logic       ph1_neg, ph2_neg, ph1_mixed, ph2_mixed;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  step_indexer dut (
    .clk(clk), .rst(rst), .home_n(home_n), .step_in(step_in), .dir_in(dir_in),
    .res_sel(res_sel), .force_mixed(force_mixed),
    .ph1_mag(ph1_mag), .ph1_neg(ph1_neg), .ph2_mag(ph2_mag), .ph2_neg(ph2_neg),
    .ph1_mixed(ph1_mixed), .ph2_mixed(ph2_mixed)
  );

  // ---------- behavioural reference ----------
  function automatic int ref_mag(int k, int ph);
    real a, v;
    a = real'(k + (ph == 0 ? 16 : 0)) * 3.14159265358979 / 32.0;
    v = $sin(a);
    if (v < 0.0) v = -v;
    return $rtoi(127.0 * v + 0.5);
  endfunction

  function automatic int ref_neg(int k, int ph);
    real a;
    a = real'(k + (ph == 0 ? 16 : 0)) * 3.14159265358979 / 32.0;
    return ($sin(a) < -1.0e-6) ? 1 : 0;
  endfunction

  function automatic int ref_inc(int r);
    if (r == 0) return 16;
    if (r == 1) return 8;
    if (r == 2) return 4;
    if (r == 3) return 2;
    return 1;
  endfunction

  int m_idx = 8, m_pulse = 0, m_full = 0, m_force = 0, m_prev = 0;
  int h_step[2] = '{0, 0};
  int h_dir[2] = '{0, 0};
  int h_res[2] = '{0, 0};
  int h_frc[2] = '{0, 0};
  int em[2] = '{90, 90};
  int en[2] = '{0, 0};
  int ex[2] = '{1, 1};

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      h_step = '{0, 0}; h_dir = '{0, 0}; h_res = '{0, 0}; h_frc = '{0, 0};
      m_prev = 0; m_idx = 8; m_pulse = 0; m_full = 0; m_force = 0;
      em = '{90, 90}; en = '{0, 0}; ex = '{1, 1};
    end else begin
      if (!home_n) begin
        m_idx = 8; m_pulse = 0;
        em = '{90, 90}; en = '{0, 0}; ex = '{1, 1};
      end else begin
        for (int ph = 0; ph < 2; ph++) begin
          int nm;
          nm = ref_mag(m_idx, ph);
          if (m_pulse != 0)
            ex[ph] = (m_force != 0) ? 1 : (m_full != 0) ? 0 : (nm < em[ph] ? 1 : 0);
          em[ph] = nm;
          en[ph] = ref_neg(m_idx, ph);
        end
        m_pulse = (h_step[1] != 0 && m_prev == 0) ? 1 : 0;
        if (m_pulse != 0) begin
          m_idx = (m_idx + (h_dir[1] != 0 ? ref_inc(h_res[1]) : 64 - ref_inc(h_res[1]))) % 64;
          m_full = (h_res[1] == 0) ? 1 : 0;
          m_force = h_frc[1];
        end
      end
      m_prev = h_step[1];
      h_step[1] = h_step[0]; h_dir[1] = h_dir[0]; h_res[1] = h_res[0]; h_frc[1] = h_frc[0];
      h_step[0] = int'(step_in); h_dir[0] = int'(dir_in);
      h_res[0] = int'(res_sel); h_frc[0] = int'(force_mixed);
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (!rst && !done) begin
      n_chk++;
      if (ph1_mag != em[0] || ph1_neg != en[0] || ph2_mag != em[1] || ph2_neg != en[1]) begin
        n_bad++;
        $display("FAIL R4 cycle %0d: got %0d/%0d %0d/%0d expected %0d/%0d %0d/%0d",
                 cyc, ph1_mag, ph1_neg, ph2_mag, ph2_neg, em[0], en[0], em[1], en[1]);
      end
      n_chk++;
      if (ph1_mixed != ex[0] || ph2_mixed != ex[1]) begin
        n_bad++;
        $display("FAIL R7 cycle %0d: decay got %0d%0d expected %0d%0d",
                 cyc, ph1_mixed, ph2_mixed, ex[0], ex[1]);
      end
    end
  end

  // ---------- directed helpers ----------
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input int m1, input int n1, input int m2, input int n2);
    chk(ph1_mag == m1 && ph1_neg == n1, req, {ph1_neg, ph1_mag}, (n1 << 7) | m1);
    chk(ph2_mag == m2 && ph2_neg == n2, req, {ph2_neg, ph2_mag}, (n2 << 7) | m2);
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_step(input int n);
    for (int i = 0; i < n; i++) begin
      step_in = 1'b1; wait_n(3);
      step_in = 1'b0; wait_n(3);
    end
  endtask

  task automatic finish_run;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    while (cyc < 150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    finish_run();
  end

  initial begin
    wait_n(4);
    rst = 1'b0;
    wait_n(1);
    // R5: reset state
    chk_out("R5", 90, 0, 90, 0);
    chk(ph1_mixed && ph2_mixed, "R5", {ph1_mixed, ph2_mixed}, 3);

    // R8 / R2: full steps upward, wrap back to home
    res_sel = 3'b000; dir_in = 1'b1;
    do_step(1);
    chk_out("R2", 90, 1, 90, 0);
    chk(!ph1_mixed && !ph2_mixed, "R8", {ph1_mixed, ph2_mixed}, 0);
    do_step(3);
    chk_out("R2", 90, 0, 90, 0);

    // R7: sixteenth steps to slot 11, winding 1 falls, winding 2 rises
    res_sel = 3'b111;
    do_step(3);
    chk_out("R4", 60, 0, 112, 0);
    chk(ph1_mixed == 1 && ph2_mixed == 0, "R7", {ph1_mixed, ph2_mixed}, 2);

    // R3: change direction and resolution without a step
    dir_in = 1'b0; res_sel = 3'b000; force_mixed = 1'b1;
    wait_n(10);
    chk_out("R3", 60, 0, 112, 0);
    chk(ph1_mixed == 1 && ph2_mixed == 0, "R3", {ph1_mixed, ph2_mixed}, 2);

    // R1: eighth step downward, slot 9
    force_mixed = 1'b0; res_sel = 3'b011;
    do_step(1);
    chk_out("R1", 81, 0, 98, 0);
    // R1: unlisted code moves one slot
    res_sel = 3'b100;
    do_step(1);
    chk_out("R1", 90, 0, 90, 0);

    // R9: forced mixed on half and full steps
    force_mixed = 1'b1; dir_in = 1'b1; res_sel = 3'b001;
    do_step(1);
    chk_out("R9", 0, 0, 127, 0);
    chk(ph1_mixed && ph2_mixed, "R9", {ph1_mixed, ph2_mixed}, 3);
    res_sel = 3'b000;
    do_step(1);
    chk(ph1_mixed && ph2_mixed, "R9", {ph1_mixed, ph2_mixed}, 3);
    force_mixed = 1'b0;

    // R6: hold at home ignores steps
    home_n = 1'b0;
    wait_n(1);
    chk_out("R6", 90, 0, 90, 0);
    res_sel = 3'b111;
    do_step(2);
    chk_out("R6", 90, 0, 90, 0);
    chk(ph1_mixed && ph2_mixed, "R6", {ph1_mixed, ph2_mixed}, 3);
    home_n = 1'b1;
    wait_n(4);
    chk_out("R6", 90, 0, 90, 0);

    // R10: latency of a single sixteenth step
    step_in = 1'b1;
    wait_n(3);
    chk_out("R10", 90, 0, 90, 0);
    wait_n(1);
    chk_out("R10", 81, 0, 98, 0);
    step_in = 1'b0;
    wait_n(3);

    // R2: downward wrap below slot 0 to slot 63
    dir_in = 1'b0;
    do_step(10);
    chk_out("R2", 126, 0, 12, 1);

    // mixed pattern sweep, compared per cycle by the model
    for (int j = 0; j < 40; j++) begin
      dir_in = j[0] ^ j[3];
      res_sel = (j % 5 == 4) ? 3'b111 : 3'(j % 4);
      force_mixed = (j % 7 == 3);
      do_step(1);
    end
    wait_n(4);
    finish_run();
  end
endmodule